// File: doc/BRIEF.md
# ULPI Transceiver Low-Power Entry Sequencer

This block is the transceiver end of a ULPI data interface, reduced to the part that moves the interface into and out of low-power mode. It decodes register-write commands from the link. When the link clears the SuspendM bit of the Function Control register, the block takes ownership of the bus by raising `dir`. It keeps the output clock running for a set number of rising edges and then drops a clock-enable. Clock gating itself happens outside this block.

While suspended, the 8-bit data bus becomes a status port that the link can read without a clock. Two bits are plain copies of the single-ended receiver line state. One bit is the OR of the enabled interrupt sources. The remaining bits are driven low. A sticky wake flag records any line-state change seen during low power. The link leaves low-power mode by raising `stp`. The block then restarts the clock-enable, sets SuspendM back to 1, and returns the bus a fixed number of clocks later.

The ULPI signals have a fixed protocol, so none of them are valid/ready streams. Every pin is plain control or status, and there is no back-pressure.

Top module: `ulpi_lp_seq`

## Requirements
- R1: After reset, `dir`, `nxt`, `low_power` and `wake_flag` are 0, `clk_en` is 1 and `phy_data` is 0.
- R2: While `dir` is low, a byte with bits [7:6] = 2'b10 on `link_data` (and `stp` low) starts a register write with address bits [5:0]. `nxt` is high for exactly the following clock cycle, and the byte present at the end of that cycle is taken as register data. `nxt` is never high while `dir` is high.
- R3: A register write completes when `stp` is sampled high after the data byte. If the address is 6'h04 and data bit 6 (SuspendM) is 0, `dir` and `low_power` are high in the next cycle.
- R4: After `dir` rises on suspend entry, `clk_en` stays high for exactly STOP_EDGES rising edges and is then held low.
- R5: A completed write to any address other than 6'h04, or to 6'h04 with data bit 6 set to 1, leaves `dir` low, `clk_en` high and `low_power` low.
- R6: While `low_power` is high, `phy_data[1:0]` equals `ls_in[1:0]` combinationally, and `phy_data[2]` and `phy_data[7:4]` are 0. While `low_power` is low, `phy_data` is 0.
- R7: While `low_power` is high, `phy_data[3]` is the OR over all i of `irq_src[i] & irq_en[i]`.
- R8: `wake_flag` rises the cycle after `ls_in` changes while `low_power` is high. It holds until the exit request and is 0 in the cycle after it.
- R9: `stp` sampled high while the clock is stopped gives `clk_en` = 1 and `low_power` = 0 in the next cycle. `dir` then stays high for exactly RESUME_EDGES cycles and falls.
- R10: `stp` asserted while the clock is still running during entry is ignored: the edge count of R4 and the stop still happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_data | input | 8 | Byte driven by the link (command and register data) |
| stp | input | 1 | Link stop strobe: ends a write, requests exit from low power |
| ls_in | input | 2 | Single-ended receiver line state |
| irq_src | input | IRQ_N | Interrupt sources |
| irq_en | input | IRQ_N | Per-source interrupt enable mask |
| dir | output | 1 | Bus direction, high when the transceiver owns the bus |
| nxt | output | 1 | Register-write handshake |
| phy_data | output | 8 | Byte driven by the transceiver (status map in low power) |
| clk_en | output | 1 | Output clock enable, low while the clock is stopped |
| low_power | output | 1 | High while SuspendM is cleared |
| wake_flag | output | 1 | Sticky line-state-change indication |

## Verification
The bench builds the block with STOP_EDGES = 7, RESUME_EDGES = 2 and IRQ_N = 5, all different from the defaults. An edge count that is fixed in the logic rather than taken from the parameter therefore shows up as a wrong count on entry or exit. A five-wide mask exercises a source above the default width. Random writes aim at address 6'h04 about a third of the time with random data bits, so both entry and non-entry cases occur often. During each suspend the line-state and interrupt inputs are re-randomised every cycle.

// File: rtl/ulpi_lp_pkg.sv
package ulpi_lp_pkg;

  // Register-write command code in bits [7:6] of the command byte
  localparam logic [1:0] CMD_REGWR = 2'b10;
  // Position of the suspend control bit inside the function-control byte
  localparam int SUSPENDM_BIT = 6;

  typedef enum logic [1:0] {
    DC_IDLE,
    DC_CMD,
    DC_WAIT
  } dec_state_e;

  typedef enum logic [1:0] {
    PW_RUN,
    PW_ENTER,
    PW_SUSPEND,
    PW_RESUME
  } pwr_state_e;

  typedef struct packed {
    logic [5:0] addr;
    logic       susp_bit;
  } reg_wr_t;

endpackage

// File: rtl/ulpi_reg_decode.sv
module ulpi_reg_decode
  import ulpi_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [7:0] link_data,
  input  logic       stp,
  output logic       nxt,
  output logic       wr_valid,
  output reg_wr_t    wr
);

  dec_state_e st_q;
  logic [5:0] addr_q;
  logic       bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DC_IDLE;
      addr_q <= '0;
      bit_q  <= 1'b1;
    end else if (!enable) begin
      st_q <= DC_IDLE;
    end else begin
      unique case (st_q)
        DC_IDLE: begin
          if (link_data[7:6] == CMD_REGWR && !stp) begin
            addr_q <= link_data[5:0];
            st_q   <= DC_CMD;
          end
        end
        DC_CMD: begin
          if (stp) begin
            st_q <= DC_IDLE;
          end else begin
            bit_q <= link_data[SUSPENDM_BIT];
            st_q  <= DC_WAIT;
          end
        end
        DC_WAIT: begin
          if (stp) st_q <= DC_IDLE;
        end
        default: st_q <= DC_IDLE;
      endcase
    end
  end

  assign nxt         = enable && (st_q == DC_CMD);
  assign wr_valid    = enable && (st_q == DC_WAIT) && stp;
  assign wr.addr     = addr_q;
  assign wr.susp_bit = bit_q;

endmodule

// File: rtl/ulpi_lp_power.sv
module ulpi_lp_power
  import ulpi_lp_pkg::*;
#(
  parameter int         STOP_EDGES   = 5,
  parameter int         RESUME_EDGES = 3,
  parameter logic [5:0] FC_ADDR      = 6'h04
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_valid,
  input  reg_wr_t wr,
  input  logic    stp,
  output logic    dir,
  output logic    clk_en,
  output logic    low_power,
  output logic    exit_pulse
);

  localparam int MAXE = (STOP_EDGES > RESUME_EDGES) ? STOP_EDGES : RESUME_EDGES;
  localparam int CW   = $clog2(MAXE + 1);
  localparam logic [CW-1:0] STOP_LAST   = CW'(STOP_EDGES - 1);
  localparam logic [CW-1:0] RESUME_LAST = CW'(RESUME_EDGES - 1);

  pwr_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          suspendm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PW_RUN;
      cnt_q      <= '0;
      suspendm_q <= 1'b1;
    end else begin
      unique case (st_q)
        PW_RUN: begin
          if (wr_valid && wr.addr == FC_ADDR) begin
            suspendm_q <= wr.susp_bit;
            if (!wr.susp_bit) begin
              st_q  <= PW_ENTER;
              cnt_q <= '0;
            end
          end
        end
        PW_ENTER: begin
          if (cnt_q == STOP_LAST) st_q <= PW_SUSPEND;
          else cnt_q <= cnt_q + 1'b1;
        end
        PW_SUSPEND: begin
          if (stp) begin
            st_q       <= PW_RESUME;
            cnt_q      <= '0;
            suspendm_q <= 1'b1;
          end
        end
        PW_RESUME: begin
          if (cnt_q == RESUME_LAST) st_q <= PW_RUN;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= PW_RUN;
      endcase
    end
  end

  assign dir        = (st_q != PW_RUN);
  assign clk_en     = (st_q != PW_SUSPEND);
  assign low_power  = !suspendm_q;
  assign exit_pulse = (st_q == PW_SUSPEND) && stp;

endmodule

// File: rtl/ulpi_lp_status.sv
module ulpi_lp_status #(
  parameter int IRQ_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_power,
  input  logic             exit_pulse,
  input  logic [1:0]       ls_in,
  input  logic [IRQ_N-1:0] irq_src,
  input  logic [IRQ_N-1:0] irq_en,
  output logic [7:0]       lp_data,
  output logic             wake_flag
);

  logic [IRQ_N-1:0] masked;
  logic [1:0]       ls_q;
  logic             irq_any;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_mask
    assign masked[i] = irq_src[i] & irq_en[i];
  end

  assign irq_any = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q      <= '0;
      wake_flag <= 1'b0;
    end else begin
      ls_q <= ls_in;
      if (exit_pulse) wake_flag <= 1'b0;
      else if (low_power && (ls_in != ls_q)) wake_flag <= 1'b1;
    end
  end

  assign lp_data = low_power ? {4'b0000, irq_any, 1'b0, ls_in} : 8'h00;

endmodule

// File: rtl/ulpi_lp_seq.sv
module ulpi_lp_seq
  import ulpi_lp_pkg::*;
#(
  parameter int         STOP_EDGES   = 5,
  parameter int         RESUME_EDGES = 3,
  parameter int         IRQ_N        = 4,
  parameter logic [5:0] FC_ADDR      = 6'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       link_data,
  input  logic             stp,
  input  logic [1:0]       ls_in,
  input  logic [IRQ_N-1:0] irq_src,
  input  logic [IRQ_N-1:0] irq_en,
  output logic             dir,
  output logic             nxt,
  output logic [7:0]       phy_data,
  output logic             clk_en,
  output logic             low_power,
  output logic             wake_flag
);

  logic    wr_valid;
  reg_wr_t wr;
  logic    exit_pulse;
  logic    dir_i;
  logic    lp_i;

  ulpi_reg_decode i_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (!dir_i),
    .link_data (link_data),
    .stp       (stp),
    .nxt       (nxt),
    .wr_valid  (wr_valid),
    .wr        (wr)
  );

  ulpi_lp_power #(
    .STOP_EDGES   (STOP_EDGES),
    .RESUME_EDGES (RESUME_EDGES),
    .FC_ADDR      (FC_ADDR)
  ) i_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr         (wr),
    .stp        (stp),
    .dir        (dir_i),
    .clk_en     (clk_en),
    .low_power  (lp_i),
    .exit_pulse (exit_pulse)
  );

  ulpi_lp_status #(
    .IRQ_N (IRQ_N)
  ) i_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_power  (lp_i),
    .exit_pulse (exit_pulse),
    .ls_in      (ls_in),
    .irq_src    (irq_src),
    .irq_en     (irq_en),
    .lp_data    (phy_data),
    .wake_flag  (wake_flag)
  );

  assign dir       = dir_i;
  assign low_power = lp_i;

endmodule

// File: rtl/ulpi_lp_chk.sv
module ulpi_lp_chk #(
  parameter int STOP_EDGES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dir,
  input logic       nxt,
  input logic       clk_en,
  input logic       low_power,
  input logic       wake_flag,
  input logic [7:0] phy_data,
  input logic [1:0] ls_in
);

  // Counts enabled clock edges since low power began (R4 window)
  logic [15:0] en_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_cnt <= '0;
    else if (!low_power) en_cnt <= '0;
    else if (clk_en) en_cnt <= en_cnt + 16'd1;
  end

  a_r2_nxt_only_link_owns: assert property (@(posedge clk) disable iff (!rst_n)
    nxt |-> !dir);

  a_r3_lp_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> dir);

  a_r4_stop_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && !clk_en) |-> (en_cnt == 16'(STOP_EDGES)));

  a_r4_stop_only_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> (dir && low_power));

  a_r6_lp_map: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (phy_data[1:0] == ls_in && phy_data[2] == 1'b0 && phy_data[7:4] == 4'h0));

  a_r8_wake_clear_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_flag) |-> !low_power);

  a_r9_restart_leaves_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (!low_power && dir));

endmodule

bind ulpi_lp_seq ulpi_lp_chk #(.STOP_EDGES(STOP_EDGES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir       (dir),
  .nxt       (nxt),
  .clk_en    (clk_en),
  .low_power (low_power),
  .wake_flag (wake_flag),
  .phy_data  (phy_data),
  .ls_in     (ls_in)
);

// File: tb/test_ulpi_lp_seq.sv
module test_ulpi_lp_seq;

  localparam int STOP_E = 7;
  localparam int RES_E  = 2;
  localparam int NIRQ   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      link_data = '0;
  logic            stp = 1'b0;
  logic [1:0]      ls_in = 2'b01;
  logic [NIRQ-1:0] irq_src = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic            dir, nxt, clk_en, low_power, wake_flag;
  logic [7:0]      phy_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ulpi_lp_seq #(
    .STOP_EDGES   (STOP_E),
    .RESUME_EDGES (RES_E),
    .IRQ_N        (NIRQ)
  ) i_ulpi_lp_seq (
    .clk (clk), .rst_n (rst_n), .link_data (link_data), .stp (stp),
    .ls_in (ls_in), .irq_src (irq_src), .irq_en (irq_en),
    .dir (dir), .nxt (nxt), .phy_data (phy_data), .clk_en (clk_en),
    .low_power (low_power), .wake_flag (wake_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lp(input logic [1:0] ls, input logic [NIRQ-1:0] s,
                                        input logic [NIRQ-1:0] e);
    return {4'b0000, |(s & e), 1'b0, ls};
  endfunction

  // Returns at the negedge after the completing stp edge
  task automatic reg_write(input logic [5:0] addr, input logic [7:0] data);
    @(negedge clk);
    link_data = {2'b10, addr};
    @(negedge clk);
    chk(nxt == 1'b1, "R2 nxt high after cmd", int'(nxt), 1);
    link_data = data;
    @(negedge clk);
    chk(nxt == 1'b0, "R2 nxt one cycle only", int'(nxt), 0);
    link_data = 8'h00;
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
  endtask

  task automatic count_entry(input bit poke_stp);
    int n = 0;
    while (clk_en && dir && n < 100) begin
      if (poke_stp && n == 1) stp = 1'b1;
      n++;
      @(negedge clk);
      stp = 1'b0;
    end
    chk(n == STOP_E, poke_stp ? "R10 stp ignored during entry" : "R4 entry edge count", n, STOP_E);
    chk(clk_en == 1'b0 && low_power == 1'b1, "R4 clock held low", int'(clk_en), 0);
  endtask

  task automatic suspend_and_exit(input int cycles);
    logic [1:0] cur = ls_in;
    bit wexp = 0;
    for (int k = 0; k < cycles; k++) begin
      logic [1:0] nls;
      if (k > 0) chk(wake_flag == wexp, "R8 wake flag", int'(wake_flag), int'(wexp));
      nls = 2'($urandom);
      ls_in = nls;
      irq_src = NIRQ'($urandom);
      irq_en = NIRQ'($urandom);
      if (nls != cur) wexp = 1;
      cur = nls;
      #1;
      chk(phy_data == exp_lp(ls_in, irq_src, irq_en), "R6/R7 low-power map",
          int'(phy_data), int'(exp_lp(ls_in, irq_src, irq_en)));
      @(negedge clk);
    end
    chk(wake_flag == wexp, "R8 wake flag before exit", int'(wake_flag), int'(wexp));
    chk(clk_en == 1'b0, "R4 clock still stopped", int'(clk_en), 0);
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
    chk(clk_en == 1'b1, "R9 clock restarted", int'(clk_en), 1);
    chk(low_power == 1'b0, "R9 low power cleared", int'(low_power), 0);
    chk(wake_flag == 1'b0, "R8 wake cleared on exit", int'(wake_flag), 0);
    chk(phy_data == 8'h00, "R6 data zero outside low power", int'(phy_data), 0);
    begin
      int n = 0;
      while (dir && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk(n == RES_E, "R9 dir hold after restart", n, RES_E);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dir == 0 && nxt == 0, "R1 dir/nxt reset", int'({dir, nxt}), 0);
    chk(clk_en == 1 && low_power == 0 && wake_flag == 0, "R1 clk_en/lp/wake reset",
        int'({clk_en, low_power, wake_flag}), 4);
    chk(phy_data == 8'h00, "R1 data reset", int'(phy_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 other address, and SuspendM written 1
    reg_write(6'h05, 8'h00);
    chk(dir == 0 && low_power == 0 && clk_en == 1, "R5 other address ignored",
        int'({dir, low_power, clk_en}), 1);
    reg_write(6'h04, 8'h40);
    chk(dir == 0 && low_power == 0, "R5 SuspendM=1 no entry", int'({dir, low_power}), 0);
    @(negedge clk);
    chk(dir == 0, "R5 dir stays low", int'(dir), 0);

    // Directed entry with interrupt masked off (R7)
    reg_write(6'h04, 8'h00);
    chk(dir == 1 && low_power == 1, "R3 dir after write", int'({dir, low_power}), 3);
    count_entry(1'b0);
    irq_src = '1;
    irq_en = '0;
    #1;
    chk(phy_data[3] == 1'b0, "R7 masked irq", int'(phy_data[3]), 0);
    irq_en = NIRQ'(1) << (NIRQ - 1);
    #1;
    chk(phy_data[3] == 1'b1, "R7 top source enabled", int'(phy_data[3]), 1);
    @(negedge clk);
    suspend_and_exit(4);

    // R10 stp during entry
    reg_write(6'h04, 8'hBF);
    chk(dir == 1, "R3 entry with other bits set", int'(dir), 1);
    count_entry(1'b1);
    suspend_and_exit(3);

    // Random writes
    for (int it = 0; it < 30; it++) begin
      logic [5:0] a;
      logic [7:0] d;
      bit enter;
      a = ($urandom % 3 == 0) ? 6'h04 : 6'($urandom);
      d = 8'($urandom);
      enter = (a == 6'h04) && !d[6];
      reg_write(a, d);
      chk(dir == enter, enter ? "R3 random entry" : "R5 random no entry", int'(dir), int'(enter));
      if (enter) begin
        count_entry(1'b0);
        suspend_and_exit(2 + int'($urandom % 5));
      end else begin
        @(negedge clk);
        chk(dir == 0 && clk_en == 1, "R5 bus kept by link", int'({dir, clk_en}), 1);
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule